// File: doc/BRIEF.md
# Processor Debug Register Port

This block is the core-side end of a small debug bus. An external host uses it to halt a processor, advance it one instruction at a time, and read its architectural state. Each host transaction carries an address, 64-bit write data, a write flag and a request line. The block answers every transaction with a single-cycle acknowledge. For reads, the returned word is valid in that same acknowledge cycle.

On the core side the block drives a stop request level and a one-cycle step pulse, and it receives a stopped flag. It also samples the program counter, machine state, condition and fixed-point exception inputs. General and special registers are reached through a window. The host first writes a register number into an index slot. The index is driven out to the register file, and a read of the data slot returns whatever the register file presents for that number.

Top module: `core_debug_port`

## Requirements
- R1: A request seen while the block is idle is acknowledged for exactly one cycle, in the cycle after the sampling clock edge. A request held high afterwards gets no further acknowledge until request has been low for at least one clock edge.
- R2: A write to address 0 with bit 3 clear and bit 0 set drives the stop request high.
- R3: A write to address 0 with bit 0 and bit 3 both clear drives the stop request low, so the core resumes.
- R4: A write to address 0 with bit 3 set, made while the stopped input is high, gives a one-cycle step pulse in the acknowledge cycle and leaves the stop request unchanged.
- R5: A write to address 0 with bit 3 set, made while the stopped input is low, gives no step pulse and leaves the stop request unchanged.
- R6: A read of address 1 returns the stopped input in bit 1, with every other bit zero. Writes to address 1 have no effect.
- R7: Reads of address 2 return the program counter input, address 3 the machine state input, and address 8 the condition input.
- R8: A read of address 9 returns the exception flags packed as summary-overflow in bit 0, carry in bit 2, 32-bit carry in bit 3, overflow in bit 4 and 32-bit overflow in bit 5, with all other bits zero.
- R9: A write to address 4 loads the low index-width bits of the write data into the index output. A read of address 4 returns the index, and a read of address 5 returns the register data input selected by it.
- R10: Reads of unmapped addresses (6, 7, 10 to 15) return zero. Writes to addresses other than 0 and 4 change neither the stop request nor the index.
- R11: Reset clears the acknowledge, the stop request, the step pulse and the index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| hostAddr | input | 4 | Register address of the transaction |
| hostWdata | input | 64 | Write data |
| hostReq | input | 1 | Transaction request |
| hostWe | input | 1 | High for a write, low for a read |
| hostAck | output | 1 | One-cycle acknowledge |
| hostRdata | output | 64 | Read data, valid with the acknowledge |
| coreStopReq | output | 1 | Asks the core to halt |
| coreStepPulse | output | 1 | Advances a halted core one instruction |
| coreStopped | input | 1 | Core is halted |
| coreNia | input | 64 | Next instruction address |
| coreMsr | input | 64 | Machine state value |
| coreCr | input | 64 | Condition value |
| xerSo | input | 1 | Summary overflow flag |
| xerCa | input | 1 | Carry flag |
| xerCa32 | input | 1 | 32-bit carry flag |
| xerOv | input | 1 | Overflow flag |
| xerOv32 | input | 1 | 32-bit overflow flag |
| regIndex | output | 7 | Selected register number |
| regData | input | 64 | Content of the selected register |

## Verification
Every result comes from one register stage. The request is sampled on a rising edge, and the acknowledge, read data, step pulse, stop request and index all take their new values just after that edge. The acknowledge drops one edge later. The bench raises request on a falling edge and samples all results on the next falling edge. At the falling edge after that it confirms that the acknowledge has gone low and that no step pulse remains. A held-request test counts acknowledge cycles over several edges to confirm there is only one.

// File: rtl/core_debug_pkg.sv
package core_debug_pkg;
  localparam int unsigned ADDR_CTRL  = 0;
  localparam int unsigned ADDR_STAT  = 1;
  localparam int unsigned ADDR_NIA   = 2;
  localparam int unsigned ADDR_MSR   = 3;
  localparam int unsigned ADDR_INDEX = 4;
  localparam int unsigned ADDR_DATA  = 5;
  localparam int unsigned ADDR_CR    = 8;
  localparam int unsigned ADDR_XER   = 9;

  localparam int unsigned CTRL_STOP_BIT = 0;
  localparam int unsigned CTRL_STEP_BIT = 3;

  typedef struct packed {
    logic accept;
    logic wrIndex;
  } dbgStrobes_t;
endpackage

// File: rtl/core_debug_ctrl.sv
module core_debug_ctrl
  import core_debug_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic              hostReq,
  input  logic              hostWe,
  input  logic              stopBit,
  input  logic              stepBit,
  input  logic              coreStopped,
  output logic              hostAck,
  output logic              coreStopReq,
  output logic              coreStepPulse,
  output dbgStrobes_t       strobes
);
  logic busy;
  logic accept;
  logic ctrlWrite;

  assign accept    = hostReq && !busy;
  assign ctrlWrite = accept && hostWe && (hostAddr == ADDR_W'(ADDR_CTRL));

  assign strobes.accept  = accept;
  assign strobes.wrIndex = accept && hostWe && (hostAddr == ADDR_W'(ADDR_INDEX));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy <= 1'b0;
    end else if (accept) begin
      busy <= 1'b1;
    end else if (!hostReq) begin
      busy <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hostAck       <= 1'b0;
      coreStopReq   <= 1'b0;
      coreStepPulse <= 1'b0;
    end else begin
      hostAck       <= accept;
      coreStepPulse <= 1'b0;
      if (ctrlWrite) begin
        if (stepBit) begin
          coreStepPulse <= coreStopped;
        end else begin
          coreStopReq <= stopBit;
        end
      end
    end
  end
endmodule

// File: rtl/core_debug_datapath.sv
module core_debug_datapath
  import core_debug_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 64,
  parameter int IDX_W  = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  dbgStrobes_t       strobes,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic              hostWe,
  input  logic [IDX_W-1:0]  indexIn,
  input  logic              coreStopped,
  input  logic [DATA_W-1:0] coreNia,
  input  logic [DATA_W-1:0] coreMsr,
  input  logic [DATA_W-1:0] coreCr,
  input  logic [4:0]        xerFlags,
  input  logic [DATA_W-1:0] regData,
  output logic [IDX_W-1:0]  regIndex,
  output logic [DATA_W-1:0] hostRdata
);
  localparam int XER_W = 6;

  logic [XER_W-1:0]  xerWord;
  logic [DATA_W-1:0] rdNext;

  // flags order: {ov32, ov, ca32, ca, so}; bit 1 of the word stays zero
  assign xerWord = {xerFlags[4:2], xerFlags[1], 1'b0, xerFlags[0]};

  always_comb begin
    rdNext = '0;
    if (!hostWe) begin
      case (hostAddr)
        ADDR_W'(ADDR_STAT):  rdNext = DATA_W'({coreStopped, 1'b0});
        ADDR_W'(ADDR_NIA):   rdNext = coreNia;
        ADDR_W'(ADDR_MSR):   rdNext = coreMsr;
        ADDR_W'(ADDR_INDEX): rdNext = DATA_W'(regIndex);
        ADDR_W'(ADDR_DATA):  rdNext = regData;
        ADDR_W'(ADDR_CR):    rdNext = coreCr;
        ADDR_W'(ADDR_XER):   rdNext = DATA_W'(xerWord);
        default:             rdNext = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regIndex  <= '0;
      hostRdata <= '0;
    end else begin
      if (strobes.wrIndex) begin
        regIndex <= indexIn;
      end
      if (strobes.accept) begin
        hostRdata <= rdNext;
      end
    end
  end
endmodule

// File: rtl/core_debug_port.sv
module core_debug_port
  import core_debug_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 64,
  parameter int IDX_W  = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostWdata,
  input  logic              hostReq,
  input  logic              hostWe,
  output logic              hostAck,
  output logic [DATA_W-1:0] hostRdata,
  output logic              coreStopReq,
  output logic              coreStepPulse,
  input  logic              coreStopped,
  input  logic [DATA_W-1:0] coreNia,
  input  logic [DATA_W-1:0] coreMsr,
  input  logic [DATA_W-1:0] coreCr,
  input  logic              xerSo,
  input  logic              xerCa,
  input  logic              xerCa32,
  input  logic              xerOv,
  input  logic              xerOv32,
  output logic [IDX_W-1:0]  regIndex,
  input  logic [DATA_W-1:0] regData
);
  dbgStrobes_t strobes;

  core_debug_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk           (clk),
    .rstN          (rstN),
    .hostAddr      (hostAddr),
    .hostReq       (hostReq),
    .hostWe        (hostWe),
    .stopBit       (hostWdata[CTRL_STOP_BIT]),
    .stepBit       (hostWdata[CTRL_STEP_BIT]),
    .coreStopped   (coreStopped),
    .hostAck       (hostAck),
    .coreStopReq   (coreStopReq),
    .coreStepPulse (coreStepPulse),
    .strobes       (strobes)
  );

  core_debug_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .hostAddr    (hostAddr),
    .hostWe      (hostWe),
    .indexIn     (hostWdata[IDX_W-1:0]),
    .coreStopped (coreStopped),
    .coreNia     (coreNia),
    .coreMsr     (coreMsr),
    .coreCr      (coreCr),
    .xerFlags    ({xerOv32, xerOv, xerCa32, xerCa, xerSo}),
    .regData     (regData),
    .regIndex    (regIndex),
    .hostRdata   (hostRdata)
  );
endmodule

// File: rtl/core_debug_checker.sv
module core_debug_checker #(
  parameter int IDX_W = 7
) (
  input logic             clk,
  input logic             rstN,
  input logic             hostReq,
  input logic             hostAck,
  input logic             coreStopReq,
  input logic             coreStepPulse,
  input logic             coreStopped,
  input logic [IDX_W-1:0] regIndex
);
  // R1
  ack_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    hostAck |=> !hostAck);

  // R1
  ack_after_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    hostAck |-> $past(hostReq));

  // R4
  step_with_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    coreStepPulse |-> hostAck);

  // R5
  step_when_stopped_chk: assert property (@(posedge clk) disable iff (!rstN)
    coreStepPulse |-> $past(coreStopped));

  // R2
  stop_change_chk: assert property (@(posedge clk) disable iff (!rstN)
    (coreStopReq != $past(coreStopReq)) |-> hostAck);

  // R9
  index_change_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regIndex != $past(regIndex)) |-> hostAck);
endmodule

bind core_debug_port core_debug_checker #(.IDX_W(IDX_W)) u_chk (
  .clk           (clk),
  .rstN          (rstN),
  .hostReq       (hostReq),
  .hostAck       (hostAck),
  .coreStopReq   (coreStopReq),
  .coreStepPulse (coreStepPulse),
  .coreStopped   (coreStopped),
  .regIndex      (regIndex)
);

// File: tb/core_debug_port_bench.sv
module core_debug_port_bench;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 64;
  localparam int IDX_W  = 7;

  localparam logic [63:0] NIA_V = 64'h0000_1234_5678_9ABC;
  localparam logic [63:0] MSR_V = 64'h8000_0000_0000_1033;
  localparam logic [63:0] CR_V  = 64'h0000_0000_2468_ACE0;
  localparam logic [63:0] RF_BASE = 64'hDEAD_0000_0000_0000;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [ADDR_W-1:0] hostAddr = '0;
  logic [DATA_W-1:0] hostWdata = '0;
  logic              hostReq = 1'b0;
  logic              hostWe = 1'b0;
  logic              hostAck;
  logic [DATA_W-1:0] hostRdata;
  logic              coreStopReq;
  logic              coreStepPulse;
  logic              coreStopped = 1'b0;
  logic [IDX_W-1:0]  regIndex;
  logic [DATA_W-1:0] regData;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  // register-file model: content derived from the selected number
  assign regData = RF_BASE | DATA_W'(regIndex);

  core_debug_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_core_debug_port (
    .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .hostWdata(hostWdata),
    .hostReq(hostReq), .hostWe(hostWe), .hostAck(hostAck), .hostRdata(hostRdata),
    .coreStopReq(coreStopReq), .coreStepPulse(coreStepPulse), .coreStopped(coreStopped),
    .coreNia(NIA_V), .coreMsr(MSR_V), .coreCr(CR_V),
    .xerSo(1'b1), .xerCa(1'b0), .xerCa32(1'b1), .xerOv(1'b1), .xerOv32(1'b0),
    .regIndex(regIndex), .regData(regData)
  );

  typedef struct packed {
    logic        we;
    logic [3:0]  addr;
    logic [63:0] wdata;
    logic        stopped;
    logic [63:0] expRd;
    logic        expStop;
    logic        expStep;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 4'd1,  64'd0,      1'b0, 64'd0,            1'b0, 1'b0, 8'd6},  // R6 running
    '{1'b1, 4'd0,  64'd1,      1'b0, 64'd0,            1'b1, 1'b0, 8'd2},  // R2 stop
    '{1'b0, 4'd1,  64'd0,      1'b1, 64'd2,            1'b1, 1'b0, 8'd6},  // R6 stopped
    '{1'b1, 4'd0,  64'd8,      1'b1, 64'd0,            1'b1, 1'b1, 8'd4},  // R4 step
    '{1'b1, 4'd0,  64'd8,      1'b0, 64'd0,            1'b1, 1'b0, 8'd5},  // R5 step ignored
    '{1'b0, 4'd2,  64'd0,      1'b1, NIA_V,            1'b1, 1'b0, 8'd7},  // R7 nia
    '{1'b0, 4'd3,  64'd0,      1'b1, MSR_V,            1'b1, 1'b0, 8'd7},  // R7 msr
    '{1'b0, 4'd8,  64'd0,      1'b1, CR_V,             1'b1, 1'b0, 8'd7},  // R7 cr
    '{1'b0, 4'd9,  64'd0,      1'b1, 64'h19,           1'b1, 1'b0, 8'd8},  // R8 xer
    '{1'b1, 4'd4,  64'hFFA5,   1'b1, 64'd0,            1'b1, 1'b0, 8'd9},  // R9 index
    '{1'b0, 4'd4,  64'd0,      1'b1, 64'h25,           1'b1, 1'b0, 8'd9},  // R9 read index
    '{1'b0, 4'd5,  64'd0,      1'b1, RF_BASE | 64'h25, 1'b1, 1'b0, 8'd9},  // R9 data
    '{1'b0, 4'd6,  64'd0,      1'b1, 64'd0,            1'b1, 1'b0, 8'd10}, // R10 unmapped
    '{1'b0, 4'd15, 64'd0,      1'b1, 64'd0,            1'b1, 1'b0, 8'd10}, // R10 unmapped
    '{1'b1, 4'd1,  '1,         1'b0, 64'd0,            1'b1, 1'b0, 8'd10}, // R10 status write
    '{1'b0, 4'd1,  64'd0,      1'b0, 64'd0,            1'b1, 1'b0, 8'd6},  // R6 still live
    '{1'b1, 4'd5,  64'h7F,     1'b0, 64'd0,            1'b1, 1'b0, 8'd10}, // R10 data write
    '{1'b0, 4'd4,  64'd0,      1'b0, 64'h25,           1'b1, 1'b0, 8'd10}, // R10 index kept
    '{1'b1, 4'd0,  64'd0,      1'b0, 64'd0,            1'b0, 1'b0, 8'd3},  // R3 release
    '{1'b1, 4'd0,  64'd9,      1'b0, 64'd0,            1'b0, 1'b0, 8'd5}   // R5 no step
  };

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // drive on falling edge, results due one rising edge later
  task automatic txn(input logic we, input logic [3:0] addr, input logic [63:0] wd,
                     output logic [63:0] rd, output logic stp, output logic stop);
    @(negedge clk);
    hostReq = 1'b1; hostWe = we; hostAddr = addr; hostWdata = wd;
    @(negedge clk);
    check("R1 ack high", 64'(hostAck), 64'd1);
    rd = hostRdata; stp = coreStepPulse; stop = coreStopReq;
    hostReq = 1'b0;
    @(negedge clk);
    check("R1 ack one cycle", 64'(hostAck), 64'd0);
    check("R4 pulse one cycle", 64'(coreStepPulse), 64'd0);
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [63:0] rd;
    logic stp, stop;
    int ackCnt;
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11 ack", 64'(hostAck), 64'd0);
    check("R11 stop", 64'(coreStopReq), 64'd0);
    check("R11 step", 64'(coreStepPulse), 64'd0);
    check("R11 index", 64'(regIndex), 64'd0);
    rstN = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      coreStopped = VECS[i].stopped;
      txn(VECS[i].we, VECS[i].addr, VECS[i].wdata, rd, stp, stop);
      if (!VECS[i].we) check($sformatf("R%0d row %0d rdata", VECS[i].req, i), rd, VECS[i].expRd);
      check($sformatf("R%0d row %0d stop", VECS[i].req, i), 64'(stop), 64'(VECS[i].expStop));
      check($sformatf("R%0d row %0d step", VECS[i].req, i), 64'(stp), 64'(VECS[i].expStep));
    end

    // R9 index visible on its output port
    txn(1'b1, 4'd4, 64'h13, rd, stp, stop);
    check("R9 index port", 64'(regIndex), 64'h13);

    // R1 held request yields one acknowledge
    @(negedge clk);
    hostReq = 1'b1; hostWe = 1'b0; hostAddr = 4'd2;
    ackCnt = 0;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      if (hostAck) ackCnt++;
    end
    check("R1 held request ack count", 64'(ackCnt), 64'd1);
    hostReq = 1'b0;
    @(negedge clk);
    txn(1'b0, 4'd2, 64'd0, rd, stp, stop);
    check("R1 next transaction data", rd, NIA_V);

    // R11 reset after activity
    txn(1'b1, 4'd0, 64'd1, rd, stp, stop);
    check("R2 stop before reset", 64'(coreStopReq), 64'd1);
    rstN = 1'b0;
    @(negedge clk);
    check("R11 stop cleared", 64'(coreStopReq), 64'd0);
    check("R11 index cleared", 64'(regIndex), 64'd0);
    rstN = 1'b1;
    @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule